// File: doc/BRIEF.md
# Age-ordered instruction issue queue

This block sits between rename and execute in an out-of-order core. Each renamed instruction enters with a sequence number, a thread number, up to two physical source tags, an optional destination tag and a flag that marks it as non-speculative. The queue holds each instruction until its sources are available. Availability is learned from a per-tag scoreboard when the instruction is inserted, and after that from tag wakeup broadcasts sent by completing instructions. Every cycle it offers up to `ISSUE_W` eligible instructions on its issue slots, with the oldest in slot 0. Age is decided only by sequence number, never by storage position.

Instructions flagged as non-speculative wait in the queue until a schedule command names their exact sequence number. An issued instruction stays in the queue, and is not offered again, until a commit command frees it or a squash command removes it. Commit frees every entry of one thread up to and including a sequence number. Squash removes every entry of one thread that is younger than a sequence number. Occupancy is limited globally by `ENTRIES` and per thread by `MAX_PER_THREAD`.

Physical tags share one index space. The integer registers come first and the floating-point registers follow them: with the default of 96 each, tags 0 to 95 are integer and tags 96 to 191 are floating point.

Top module: `age_issue_queue`

## Requirements
- R1: Among eligible entries the issue slots carry the smallest sequence numbers. Slot 0 holds the oldest, and each valid slot k>0 holds a larger sequence number than slot k-1. `iss_seq` slot k is bits [k*16 +: 16].
- R2: At most `ISSUE_W` entries are offered per cycle, and the valid slots are packed from slot 0 upward. An offered entry is marked issued at the next clock edge and is never offered again.
- R3: An entry inserted with `in_nonspec`=1 is not offered, even when its sources are ready, until a cycle with `sched_valid`=1 and `sched_seq` equal to its sequence number. It can be offered from the following cycle.
- R4: A cycle with `commit_valid`=1 removes, at the clock edge, every entry whose thread equals `commit_tid` and whose sequence number is at most `commit_seq`, whether or not that entry has issued.
- R5: A cycle with `squash_valid`=1 removes, at the clock edge, every entry of `squash_tid` whose sequence number is strictly greater than `squash_seq`, including parked non-speculative entries. In that cycle `in_ready` is 0 for inserts of the same thread.
- R6: `free_count` equals `ENTRIES` minus the number of occupied entries. `full_all` is 1 when no entry is free. `full_thread[t]` is 1 when thread t holds `MAX_PER_THREAD` entries.
- R7: `in_ready` is 0 while `full_all` is 1 or `full_thread[in_tid]` is 1. An insert offered with `in_ready`=0 changes no state.
- R8: A cycle with `wake_valid`=1 marks ready every waiting source whose tag equals `wake_tag`. The entry can be offered in the next cycle.
- R9: A source is ready at insertion if its scoreboard bit is 1, or if a wakeup of the same tag arrives in the insert cycle. An accepted insert with `in_dst_valid`=1 clears the bit of its destination tag, and a wakeup sets it.
- R10: After reset the queue is empty, `free_count`=`ENTRIES`, no slot is valid, and every scoreboard bit is 1.
- R11: Tags are compared on the full unified index. A wakeup of a floating-point tag (96 and above) releases only sources that carry that exact tag, and no integer source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Insert request |
| in_ready | output | 1 | Insert accepted this cycle when in_valid is 1 |
| in_seq | input | 16 | Sequence number of the inserted instruction |
| in_tid | input | 1 | Thread of the inserted instruction |
| in_src0_valid | input | 1 | First source present |
| in_src0_tag | input | 8 | First source physical tag |
| in_src1_valid | input | 1 | Second source present |
| in_src1_tag | input | 8 | Second source physical tag |
| in_dst_valid | input | 1 | Destination present |
| in_dst_tag | input | 8 | Destination physical tag |
| in_nonspec | input | 1 | Park until scheduled by sequence number |
| wake_valid | input | 1 | Completion broadcast |
| wake_tag | input | 8 | Tag produced by the completing instruction |
| sched_valid | input | 1 | Release a parked non-speculative entry |
| sched_seq | input | 16 | Sequence number to release |
| commit_valid | input | 1 | Commit command |
| commit_seq | input | 16 | Free entries up to and including this number |
| commit_tid | input | 1 | Thread that commits |
| squash_valid | input | 1 | Squash command |
| squash_seq | input | 16 | Remove entries younger than this number |
| squash_tid | input | 1 | Thread being squashed |
| iss_valid | output | ISSUE_W | Issue slot valid, one bit per slot |
| iss_seq | output | ISSUE_W*16 | Sequence number per issue slot |
| iss_tid | output | ISSUE_W | Thread per issue slot |
| free_count | output | $clog2(ENTRIES+1) | Number of free entries |
| full_all | output | 1 | No free entry |
| full_thread | output | 2 | Thread at its entry limit, one bit per thread |

## Verification
The hardest condition to reach from the ports is several eligible entries at once whose age order differs from their storage order, with parked entries and waiting sources mixed in. Reaching it needs frees that open low slots under live older entries, followed by one wakeup that releases several instructions in the same cycle. The stimulus builds this in directed steps: producers, then consumers that share a waiting tag, then a single broadcast. It then runs a long stretch of random traffic. In that traffic, random commits and squashes recycle slots while inserts, wakeups on both integer and floating-point tags, and schedule commands overlap. A behavioural model predicts the slot contents, counts and `in_ready` on every cycle.

// File: rtl/iq_pkg.sv
package iq_pkg;
    localparam int IQ_THREADS  = 2;
    localparam int IQ_INT_TAGS = 96;
    localparam int IQ_FP_TAGS  = 96;
    localparam int IQ_TAGS     = IQ_INT_TAGS + IQ_FP_TAGS;
    localparam int IQ_TAG_W    = $clog2(IQ_TAGS);
    localparam int IQ_SEQ_W    = 16;
    localparam int IQ_TID_W    = (IQ_THREADS > 1) ? $clog2(IQ_THREADS) : 1;

    typedef struct packed {
        logic                valid;
        logic [IQ_TID_W-1:0] tid;
        logic [IQ_SEQ_W-1:0] seq;
        logic [IQ_TAG_W-1:0] src0_tag;
        logic                src0_rdy;
        logic [IQ_TAG_W-1:0] src1_tag;
        logic                src1_rdy;
        logic                nonspec;
        logic                released;
        logic                issued;
    } iq_entry_t;
endpackage

// File: rtl/iq_scoreboard.sv
module iq_scoreboard
    import iq_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                set_valid,
    input  logic [IQ_TAG_W-1:0] set_tag,
    input  logic                clr_valid,
    input  logic [IQ_TAG_W-1:0] clr_tag,
    input  logic [IQ_TAG_W-1:0] rd_tag_a,
    input  logic [IQ_TAG_W-1:0] rd_tag_b,
    output logic                rd_a,
    output logic                rd_b
);
    logic [IQ_TAGS-1:0] sb_d, sb_q;
    logic set_ok, clr_ok;

    assign set_ok = set_valid && (int'(set_tag) < IQ_TAGS);
    assign clr_ok = clr_valid && (int'(clr_tag) < IQ_TAGS);

    // A new producer claims its tag after any completion in the same cycle.
    always_comb begin
        sb_d = sb_q;
        if (set_ok) sb_d[set_tag] = 1'b1;
        if (clr_ok) sb_d[clr_tag] = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sb_q <= '1;
        else        sb_q <= sb_d;
    end

    assign rd_a = (int'(rd_tag_a) < IQ_TAGS) ? sb_q[rd_tag_a] : 1'b1;
    assign rd_b = (int'(rd_tag_b) < IQ_TAGS) ? sb_q[rd_tag_b] : 1'b1;

    assert_wake_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
        set_ok && !(clr_ok && clr_tag == set_tag) |=> sb_q[$past(set_tag)]);

    assert_producer_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clr_ok |=> !sb_q[$past(clr_tag)]);
endmodule

// File: rtl/iq_age_select.sv
module iq_age_select
    import iq_pkg::*;
#(
    parameter  int N     = 8,
    parameter  int W     = 2,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [N-1:0]          elig,
    input  logic [N*IQ_SEQ_W-1:0] seq_flat,
    output logic [W*N-1:0]        grant_flat,
    output logic [W-1:0]          pick_valid,
    output logic [W*IDX_W-1:0]    pick_idx
);
    // W passes, each finding the smallest sequence number still left.
    always_comb begin
        logic [N-1:0]          left;
        logic                  found;
        logic [IQ_SEQ_W-1:0]   best;
        logic [IDX_W-1:0]      bidx;
        left       = elig;
        grant_flat = '0;
        pick_valid = '0;
        pick_idx   = '0;
        for (int k = 0; k < W; k++) begin
            found = 1'b0;
            best  = '0;
            bidx  = '0;
            for (int i = 0; i < N; i++) begin
                if (left[i] && (!found || seq_flat[i*IQ_SEQ_W +: IQ_SEQ_W] < best)) begin
                    found = 1'b1;
                    best  = seq_flat[i*IQ_SEQ_W +: IQ_SEQ_W];
                    bidx  = IDX_W'(i);
                end
            end
            if (found) begin
                pick_valid[k]                   = 1'b1;
                pick_idx[k*IDX_W +: IDX_W]      = bidx;
                grant_flat[k*N + int'(bidx)]    = 1'b1;
                left[bidx]                      = 1'b0;
            end
        end
    end

    for (genvar k = 0; k < W; k++) begin : g_slot_chk
        assert_grant_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(grant_flat[k*N +: N]));
        assert_grant_eligible_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (grant_flat[k*N +: N] & ~elig) == '0);
        if (k > 0) begin : g_pair
            assert_grant_disjoint_R2: assert property (@(posedge clk) disable iff (!rst_n)
                (grant_flat[k*N +: N] & grant_flat[(k-1)*N +: N]) == '0);
        end
    end
endmodule

// File: rtl/age_issue_queue.sv
module age_issue_queue
    import iq_pkg::*;
#(
    parameter int ENTRIES        = 8,
    parameter int ISSUE_W        = 2,
    parameter int MAX_PER_THREAD = 5
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          in_valid,
    output logic                          in_ready,
    input  logic [IQ_SEQ_W-1:0]           in_seq,
    input  logic [IQ_TID_W-1:0]           in_tid,
    input  logic                          in_src0_valid,
    input  logic [IQ_TAG_W-1:0]           in_src0_tag,
    input  logic                          in_src1_valid,
    input  logic [IQ_TAG_W-1:0]           in_src1_tag,
    input  logic                          in_dst_valid,
    input  logic [IQ_TAG_W-1:0]           in_dst_tag,
    input  logic                          in_nonspec,
    input  logic                          wake_valid,
    input  logic [IQ_TAG_W-1:0]           wake_tag,
    input  logic                          sched_valid,
    input  logic [IQ_SEQ_W-1:0]           sched_seq,
    input  logic                          commit_valid,
    input  logic [IQ_SEQ_W-1:0]           commit_seq,
    input  logic [IQ_TID_W-1:0]           commit_tid,
    input  logic                          squash_valid,
    input  logic [IQ_SEQ_W-1:0]           squash_seq,
    input  logic [IQ_TID_W-1:0]           squash_tid,
    output logic [ISSUE_W-1:0]            iss_valid,
    output logic [ISSUE_W*IQ_SEQ_W-1:0]   iss_seq,
    output logic [ISSUE_W*IQ_TID_W-1:0]   iss_tid,
    output logic [$clog2(ENTRIES+1)-1:0]  free_count,
    output logic                          full_all,
    output logic [IQ_THREADS-1:0]         full_thread
);
    localparam int CNT_W = $clog2(ENTRIES + 1);
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    typedef struct packed {
        iq_entry_t [ENTRIES-1:0] ent;
    } iq_state_t;

    iq_state_t st_d, st_q;

    logic [CNT_W-1:0]             occ_all;
    logic [CNT_W-1:0]             occ_thr [IQ_THREADS];
    logic [IDX_W-1:0]             ins_slot;
    logic                         ins_has;
    logic                         accept;
    logic                         sb_rd0, sb_rd1;
    iq_entry_t                    new_ent;
    logic [ENTRIES-1:0]           elig;
    logic [ENTRIES*IQ_SEQ_W-1:0]  seq_flat;
    logic [ISSUE_W*ENTRIES-1:0]   grant_flat;
    logic [ISSUE_W-1:0]           pick_valid;
    logic [ISSUE_W*IDX_W-1:0]     pick_idx;
    logic [ENTRIES-1:0]           granted;
    logic [ENTRIES-1:0]           commit_hit;
    logic [ENTRIES-1:0]           squash_hit;

    // ---------------- occupancy and free slot ----------------
    always_comb begin
        occ_all  = '0;
        ins_slot = '0;
        ins_has  = 1'b0;
        for (int t = 0; t < IQ_THREADS; t++) occ_thr[t] = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (st_q.ent[i].valid) begin
                occ_all                   = occ_all + CNT_W'(1);
                occ_thr[st_q.ent[i].tid]  = occ_thr[st_q.ent[i].tid] + CNT_W'(1);
            end
        end
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!st_q.ent[i].valid) begin
                ins_slot = IDX_W'(i);
                ins_has  = 1'b1;
            end
        end
    end

    assign free_count = CNT_W'(ENTRIES) - occ_all;
    assign full_all   = !ins_has;

    for (genvar t = 0; t < IQ_THREADS; t++) begin : g_thr
        assign full_thread[t] = (occ_thr[t] >= CNT_W'(MAX_PER_THREAD));
        assert_thread_limit_R6: assert property (@(posedge clk) disable iff (!rst_n)
            occ_thr[t] <= CNT_W'(MAX_PER_THREAD));
    end

    assign in_ready = ins_has && !full_thread[in_tid]
                   && !(squash_valid && squash_tid == in_tid);
    assign accept   = in_valid && in_ready;

    // ---------------- scoreboard ----------------
    iq_scoreboard u_sb (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_valid (wake_valid),
        .set_tag   (wake_tag),
        .clr_valid (accept && in_dst_valid),
        .clr_tag   (in_dst_tag),
        .rd_tag_a  (in_src0_tag),
        .rd_tag_b  (in_src1_tag),
        .rd_a      (sb_rd0),
        .rd_b      (sb_rd1)
    );

    // ---------------- new entry ----------------
    always_comb begin
        new_ent          = '0;
        new_ent.valid    = 1'b1;
        new_ent.tid      = in_tid;
        new_ent.seq      = in_seq;
        new_ent.nonspec  = in_nonspec;
        new_ent.src0_tag = in_src0_valid ? in_src0_tag : '0;
        new_ent.src1_tag = in_src1_valid ? in_src1_tag : '0;
        new_ent.src0_rdy = !in_src0_valid || sb_rd0 || (wake_valid && wake_tag == in_src0_tag);
        new_ent.src1_rdy = !in_src1_valid || sb_rd1 || (wake_valid && wake_tag == in_src1_tag);
    end

    // ---------------- eligibility and selection ----------------
    always_comb begin
        for (int i = 0; i < ENTRIES; i++) begin
            elig[i] = st_q.ent[i].valid && !st_q.ent[i].issued
                   && st_q.ent[i].src0_rdy && st_q.ent[i].src1_rdy
                   && (!st_q.ent[i].nonspec || st_q.ent[i].released);
            seq_flat[i*IQ_SEQ_W +: IQ_SEQ_W] = st_q.ent[i].seq;
        end
    end

    iq_age_select #(.N(ENTRIES), .W(ISSUE_W)) u_sel (
        .clk        (clk),
        .rst_n      (rst_n),
        .elig       (elig),
        .seq_flat   (seq_flat),
        .grant_flat (grant_flat),
        .pick_valid (pick_valid),
        .pick_idx   (pick_idx)
    );

    always_comb begin
        granted = '0;
        for (int k = 0; k < ISSUE_W; k++)
            granted = granted | grant_flat[k*ENTRIES +: ENTRIES];
    end

    always_comb begin
        iss_valid = pick_valid;
        iss_seq   = '0;
        iss_tid   = '0;
        for (int k = 0; k < ISSUE_W; k++) begin
            if (pick_valid[k]) begin
                iss_seq[k*IQ_SEQ_W +: IQ_SEQ_W] = st_q.ent[pick_idx[k*IDX_W +: IDX_W]].seq;
                iss_tid[k*IQ_TID_W +: IQ_TID_W] = st_q.ent[pick_idx[k*IDX_W +: IDX_W]].tid;
            end
        end
    end

    // ---------------- retirement and squash ----------------
    always_comb begin
        for (int i = 0; i < ENTRIES; i++) begin
            commit_hit[i] = commit_valid && st_q.ent[i].tid == commit_tid
                         && st_q.ent[i].seq <= commit_seq;
            squash_hit[i] = squash_valid && st_q.ent[i].tid == squash_tid
                         && st_q.ent[i].seq > squash_seq;
        end
    end

    // ---------------- next state ----------------
    always_comb begin
        st_d = st_q;
        for (int i = 0; i < ENTRIES; i++) begin
            if (st_q.ent[i].valid) begin
                if (wake_valid && st_q.ent[i].src0_tag == wake_tag) st_d.ent[i].src0_rdy = 1'b1;
                if (wake_valid && st_q.ent[i].src1_tag == wake_tag) st_d.ent[i].src1_rdy = 1'b1;
                if (sched_valid && st_q.ent[i].nonspec && st_q.ent[i].seq == sched_seq)
                    st_d.ent[i].released = 1'b1;
                if (granted[i]) st_d.ent[i].issued = 1'b1;
                if (commit_hit[i] || squash_hit[i]) st_d.ent[i].valid = 1'b0;
            end
        end
        if (accept) st_d.ent[ins_slot] = new_ent;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // ---------------- assertions ----------------
    for (genvar k = 1; k < ISSUE_W; k++) begin : g_order_chk
        assert_slot_order_R1: assert property (@(posedge clk) disable iff (!rst_n)
            iss_valid[k] |-> iss_valid[k-1]
                && iss_seq[k*IQ_SEQ_W +: IQ_SEQ_W] > iss_seq[(k-1)*IQ_SEQ_W +: IQ_SEQ_W]);
    end

    for (genvar i = 0; i < ENTRIES; i++) begin : g_ent_chk
        assert_issued_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
            st_q.ent[i].valid && st_q.ent[i].issued |=> !st_q.ent[i].valid || st_q.ent[i].issued);
        assert_commit_frees_R4: assert property (@(posedge clk) disable iff (!rst_n)
            commit_valid && st_q.ent[i].valid && st_q.ent[i].tid == commit_tid
                && st_q.ent[i].seq <= commit_seq |=> !st_q.ent[i].valid);
        assert_squash_removes_R5: assert property (@(posedge clk) disable iff (!rst_n)
            squash_valid && st_q.ent[i].valid && st_q.ent[i].tid == squash_tid
                && st_q.ent[i].seq > squash_seq |=> !st_q.ent[i].valid);
    end
endmodule

// File: tb/tb_age_issue_queue.sv
module tb_age_issue_queue;
    import iq_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int ENTRIES    = 8;
    localparam int ISSUE_W    = 2;
    localparam int MAXT       = 5;
    localparam int CNT_W      = $clog2(ENTRIES + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid, in_ready, in_src0_valid, in_src1_valid, in_dst_valid, in_nonspec;
    logic [IQ_SEQ_W-1:0] in_seq, sched_seq, commit_seq, squash_seq;
    logic [IQ_TID_W-1:0] in_tid, commit_tid, squash_tid;
    logic [IQ_TAG_W-1:0] in_src0_tag, in_src1_tag, in_dst_tag, wake_tag;
    logic wake_valid, sched_valid, commit_valid, squash_valid;
    logic [ISSUE_W-1:0] iss_valid;
    logic [ISSUE_W*IQ_SEQ_W-1:0] iss_seq;
    logic [ISSUE_W*IQ_TID_W-1:0] iss_tid;
    logic [CNT_W-1:0] free_count;
    logic full_all;
    logic [IQ_THREADS-1:0] full_thread;

    always #(CLK_PERIOD / 2) clk = ~clk;

    age_issue_queue #(.ENTRIES(ENTRIES), .ISSUE_W(ISSUE_W), .MAX_PER_THREAD(MAXT)) dut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_seq(in_seq), .in_tid(in_tid),
        .in_src0_valid(in_src0_valid), .in_src0_tag(in_src0_tag),
        .in_src1_valid(in_src1_valid), .in_src1_tag(in_src1_tag),
        .in_dst_valid(in_dst_valid), .in_dst_tag(in_dst_tag), .in_nonspec(in_nonspec),
        .wake_valid(wake_valid), .wake_tag(wake_tag),
        .sched_valid(sched_valid), .sched_seq(sched_seq),
        .commit_valid(commit_valid), .commit_seq(commit_seq), .commit_tid(commit_tid),
        .squash_valid(squash_valid), .squash_seq(squash_seq), .squash_tid(squash_tid),
        .iss_valid(iss_valid), .iss_seq(iss_seq), .iss_tid(iss_tid),
        .free_count(free_count), .full_all(full_all), .full_thread(full_thread)
    );

    // ---------------- behavioural reference ----------------
    typedef struct {
        int seq; int tid; int t0; int t1;
        bit r0; bit r1; bit ns; bit rel; bit iss;
    } ment_t;

    ment_t mq[$];
    bit    sb[IQ_TAGS];
    int    pk_n;
    int    pk_seq[ISSUE_W];
    int    pk_idx[ISSUE_W];
    int    errors = 0;
    int    checks = 0;
    int    next_seq = 1;
    bit    done = 0;
    string phase = "R10 reset";

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s [%s]: actual=%0d expected=%0d", req, phase, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    function automatic bit m_elig(ment_t e);
        return !e.iss && e.r0 && e.r1 && (!e.ns || e.rel);
    endfunction

    function automatic int m_cnt(int t);
        int c = 0;
        foreach (mq[j]) if (mq[j].tid == t) c++;
        return c;
    endfunction

    task automatic m_pick();
        pk_n = 0;
        for (int k = 0; k < ISSUE_W; k++) begin
            int b;
            b = -1;
            pk_idx[k] = -1;
            pk_seq[k] = 0;
            for (int j = 0; j < mq.size(); j++) begin
                bit taken;
                taken = 0;
                for (int q = 0; q < k; q++) if (pk_idx[q] == j) taken = 1;
                if (!taken && m_elig(mq[j]) && (b < 0 || mq[j].seq < mq[b].seq)) b = j;
            end
            if (b >= 0) begin
                pk_idx[k] = b;
                pk_seq[k] = mq[b].seq;
                pk_n++;
            end
        end
    endtask

    task automatic clr_inputs();
        in_valid = 0; in_seq = '0; in_tid = '0; in_nonspec = 0;
        in_src0_valid = 0; in_src0_tag = '0; in_src1_valid = 0; in_src1_tag = '0;
        in_dst_valid = 0; in_dst_tag = '0;
        wake_valid = 0; wake_tag = '0; sched_valid = 0; sched_seq = '0;
        commit_valid = 0; commit_seq = '0; commit_tid = '0;
        squash_valid = 0; squash_seq = '0; squash_tid = '0;
    endtask

    // drive an insert; a source or destination tag below 0 means absent
    task automatic ins(int tid, int s0, int s1, int d, bit ns);
        in_valid      = 1;
        in_seq        = IQ_SEQ_W'(next_seq);
        next_seq++;
        in_tid        = IQ_TID_W'(tid);
        in_nonspec    = ns;
        in_src0_valid = (s0 >= 0);
        in_src0_tag   = IQ_TAG_W'((s0 >= 0) ? s0 : 0);
        in_src1_valid = (s1 >= 0);
        in_src1_tag   = IQ_TAG_W'((s1 >= 0) ? s1 : 0);
        in_dst_valid  = (d >= 0);
        in_dst_tag    = IQ_TAG_W'((d >= 0) ? d : 0);
    endtask

    // compare this cycle, then advance the reference across the clock edge
    task automatic step();
        int  occ;
        bit  exp_ready;
        bit  acc;
        ment_t kept[$];
        ment_t e;
        #1;
        m_pick();
        for (int k = 0; k < ISSUE_W; k++) begin
            chk("R2 slot valid", int'(iss_valid[k]), (k < pk_n) ? 1 : 0);
            if (k < pk_n)
                chk("R1 oldest first", int'(iss_seq[k*IQ_SEQ_W +: IQ_SEQ_W]), pk_seq[k]);
        end
        occ = mq.size();
        chk("R6 free count", int'(free_count), ENTRIES - occ);
        chk("R6 full flag", int'(full_all), (occ == ENTRIES) ? 1 : 0);
        for (int t = 0; t < IQ_THREADS; t++)
            chk("R6 thread full", int'(full_thread[t]), (m_cnt(t) >= MAXT) ? 1 : 0);
        exp_ready = (occ < ENTRIES) && (m_cnt(int'(in_tid)) < MAXT)
                 && !(squash_valid && squash_tid == in_tid);
        chk("R7 in_ready", int'(in_ready), exp_ready ? 1 : 0);
        acc = in_valid && exp_ready;

        for (int k = 0; k < pk_n; k++) mq[pk_idx[k]].iss = 1;
        foreach (mq[j]) begin
            if (wake_valid && mq[j].t0 == int'(wake_tag)) mq[j].r0 = 1;
            if (wake_valid && mq[j].t1 == int'(wake_tag)) mq[j].r1 = 1;
            if (sched_valid && mq[j].ns && mq[j].seq == int'(sched_seq)) mq[j].rel = 1;
        end
        foreach (mq[j]) begin
            bit gone;
            gone = (commit_valid && mq[j].tid == int'(commit_tid) && mq[j].seq <= int'(commit_seq))
                || (squash_valid && mq[j].tid == int'(squash_tid) && mq[j].seq > int'(squash_seq));
            if (!gone) kept.push_back(mq[j]);
        end
        mq = kept;
        if (acc) begin
            e.seq = int'(in_seq);
            e.tid = int'(in_tid);
            e.t0  = in_src0_valid ? int'(in_src0_tag) : -1;
            e.t1  = in_src1_valid ? int'(in_src1_tag) : -1;
            e.r0  = !in_src0_valid || sb[in_src0_tag] || (wake_valid && wake_tag == in_src0_tag);
            e.r1  = !in_src1_valid || sb[in_src1_tag] || (wake_valid && wake_tag == in_src1_tag);
            e.ns  = in_nonspec;
            e.rel = 0;
            e.iss = 0;
            mq.push_back(e);
        end
        if (wake_valid) sb[wake_tag] = 1;
        if (acc && in_dst_valid) sb[in_dst_tag] = 0;
        @(negedge clk);
        clr_inputs();
    endtask

    function automatic int pool_tag();
        return ($urandom % 2 == 0) ? int'($urandom % 8) : 96 + int'($urandom % 8);
    endfunction

    function automatic int iss_slot_seq(int k);
        return int'(iss_seq[k*IQ_SEQ_W +: IQ_SEQ_W]);
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        int s_a, s_b, s_c, s_d;
        clr_inputs();
        foreach (sb[t]) sb[t] = 1;
        repeat (3) @(negedge clk);
        chk("R10 free after reset", int'(free_count), ENTRIES);
        chk("R10 no issue in reset", int'(iss_valid), 0);
        rst_n = 1;
        step();

        // non-speculative parking
        phase = "R3 parking";
        s_a = next_seq; ins(0, -1, -1, -1, 1); step();
        chk("R3 parked despite ready sources", int'(iss_valid[0]), 0);
        step();
        chk("R3 still parked", int'(iss_valid[0]), 0);
        sched_valid = 1; sched_seq = IQ_SEQ_W'(s_a); step();
        chk("R3 released by schedule", int'(iss_valid[0]), 1);
        chk("R3 released entry", iss_slot_seq(0), s_a);
        step();
        chk("R2 not offered twice", int'(iss_valid[0]), 0);
        commit_valid = 1; commit_tid = '0; commit_seq = IQ_SEQ_W'(s_a); step();
        chk("R4 commit frees issued entry", int'(free_count), ENTRIES);

        // wakeup on unified tag space
        phase = "R8 R11 wakeup";
        ins(0, -1, -1, 100, 0); step();
        ins(0, -1, -1, 4, 0); step();
        s_b = next_seq; ins(1, 100, -1, -1, 0); step();
        s_c = next_seq; ins(1, -1, 4, -1, 0); step();
        chk("R8 consumers wait", int'(iss_valid[0]), 0);
        wake_valid = 1; wake_tag = 8'd100; step();
        chk("R11 fp wake releases fp consumer", iss_slot_seq(0), s_b);
        chk("R11 integer consumer untouched", int'(iss_valid[1]), 0);
        wake_valid = 1; wake_tag = 8'd4; step();
        chk("R8 integer wake releases consumer", iss_slot_seq(0), s_c);

        // same-cycle wake at insertion
        phase = "R9 insert capture";
        ins(0, -1, -1, 5, 0); step();
        s_d = next_seq; ins(0, -1, 5, -1, 0); wake_valid = 1; wake_tag = 8'd5; step();
        chk("R9 same-cycle wake captured", int'(iss_valid[0]), 1);
        chk("R9 captured entry", iss_slot_seq(0), s_d);
        commit_valid = 1; commit_tid = '0; commit_seq = '1; step();
        commit_valid = 1; commit_tid = 1'b1; commit_seq = '1; step();

        // several ready at once: age order across slots
        phase = "R1 age order";
        ins(1, -1, -1, 6, 0); step();
        s_a = next_seq; ins(0, 6, -1, -1, 0); step();
        ins(0, 6, -1, -1, 0); step();
        ins(1, -1, 6, -1, 0); step();
        commit_valid = 1; commit_tid = 1'b1; commit_seq = IQ_SEQ_W'(s_a); step();
        s_b = next_seq; ins(1, 6, -1, -1, 0); step();
        wake_valid = 1; wake_tag = 8'd6; step();
        chk("R1 slot0 oldest", iss_slot_seq(0), s_a);
        chk("R1 slot1 next oldest", iss_slot_seq(1), s_a + 1);
        step();
        chk("R1 remaining in age order", iss_slot_seq(0), s_a + 2);
        chk("R1 refilled slot is youngest", iss_slot_seq(1), s_b);

        // squash including parked and same-thread insert refusal
        phase = "R5 squash";
        commit_valid = 1; commit_tid = '0; commit_seq = '1; step();
        commit_valid = 1; commit_tid = 1'b1; commit_seq = '1; step();
        s_a = next_seq; ins(1, -1, -1, -1, 0); step();
        ins(1, -1, -1, -1, 1); step();
        ins(1, 9, -1, -1, 0); step();
        ins(0, -1, -1, 9, 0); step();
        ins(1, -1, -1, -1, 0); squash_valid = 1; squash_tid = 1'b1; squash_seq = IQ_SEQ_W'(s_a); step();
        chk("R5 younger and parked removed", int'(free_count), ENTRIES - 2);

        // thread and global limits
        phase = "R6 R7 limits";
        commit_valid = 1; commit_tid = '0; commit_seq = '1; step();
        commit_valid = 1; commit_tid = 1'b1; commit_seq = '1; step();
        for (int n = 0; n < MAXT + 1; n++) begin ins(0, 9, -1, -1, 0); step(); end
        chk("R6 thread limit reached", int'(full_thread[0]), 1);
        for (int n = 0; n < 4; n++) begin ins(1, 9, -1, -1, 0); step(); end
        chk("R6 queue full", int'(full_all), 1);
        chk("R7 no free entry left", int'(free_count), 0);
        commit_valid = 1; commit_tid = '0; commit_seq = '1; step();
        commit_valid = 1; commit_tid = 1'b1; commit_seq = '1; step();

        // random traffic against the reference
        phase = "random mix";
        for (int cyc = 0; cyc < 4000; cyc++) begin
            if ($urandom % 3 != 0) begin
                int d;
                d = -1;
                for (int tries = 0; tries < 4; tries++) begin
                    int t;
                    t = pool_tag();
                    if (sb[t] && d < 0) d = t;
                end
                ins(int'($urandom % 2),
                    ($urandom % 2 == 0) ? pool_tag() : -1,
                    ($urandom % 2 == 0) ? pool_tag() : -1,
                    d, ($urandom % 6 == 0));
            end
            if ($urandom % 3 == 0) begin
                wake_valid = 1;
                wake_tag = IQ_TAG_W'(pool_tag());
                if (in_valid && in_dst_valid && wake_tag == in_dst_tag) wake_valid = 0;
            end
            if ($urandom % 4 == 0 && mq.size() > 0) begin
                int j;
                j = int'($urandom % mq.size());
                if (mq[j].ns) begin sched_valid = 1; sched_seq = IQ_SEQ_W'(mq[j].seq); end
            end
            if ($urandom % 5 == 0 && mq.size() > 0) begin
                int j;
                j = int'($urandom % mq.size());
                commit_valid = 1;
                commit_tid = IQ_TID_W'(mq[j].tid);
                commit_seq = IQ_SEQ_W'(mq[j].seq);
            end
            if ($urandom % 40 == 0 && mq.size() > 0) begin
                int j;
                j = int'($urandom % mq.size());
                squash_valid = 1;
                squash_tid = IQ_TID_W'(mq[j].tid);
                squash_seq = IQ_SEQ_W'(mq[j].seq);
            end
            step();
        end
        finish_run();
    end
endmodule